// File: doc/BRIEF.md
# Scattered-Map 64-Source Interrupt Controller

This block gathers up to 64 active-low interrupt lines into one request output for a processor. Every source number owns one pending bit and one mask bit, and both sit at a fixed position in either a "high" or a "low" 32-bit word. The source number is not simple arithmetic on that position: neighbouring sources land in different words and count in opposite directions. Software enables sources through two mask words. It acknowledges them by writing ones to two pending words. It reads a vector word that holds the number of the lowest-numbered source that is both pending and enabled.

Most sources are fixed active-low level inputs. Seven external lines (19 to 25) and sixteen port lines (48 to 63) are steered by a sense word. An external line is either level-sensitive or falling-edge. A port line detects either both edges or only falling edges. Each line passes through a synchronizer, and its detector then works in one of four modes: OFF, LEVEL, FALL or BOTH. The mode is picked each cycle from the source's class and its sense bit. A detector goes from LEVEL to FALL, or from BOTH to FALL, when software sets the sense bit, and goes back when software clears it. Fixed and unused sources never change mode.

Top module: `scatter_intc`

## Requirements
- R1: After reset, both mask words, both pending words and the sense word read zero, the vector word reads zero and `irq_out` is low.
- R2: The bus word offsets are: 0 mask high, 1 mask low, 2 pending high, 3 pending low, 4 sense, 5 vector. A write takes effect at the clock edge where `bus_en` and `bus_we` are both high. Read data is valid in the same cycle as `bus_en` with `bus_we` low. Unmapped offsets read zero.
- R3: Source n maps to a word and a bit as follows. Sources 1..15 use the high word at bit 16-n. Sources 32..47 use the high word at bit 63-n. Sources 16..18 use the low word at bit 18-n. Sources 19..30 use the low word at bit 33-n. Sources 48..63 use the low word at bit n-32. Mask and pending bits use this same position.
- R4: Writing a 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a new event for a source and a clear of its bit fall in the same cycle, the bit ends up set.
- R5: A mask bit of 1 enables its source. Pending bits set whether masked or not. `irq_out` is high exactly when some pending bit has its mask bit set, so all-zero masks keep it low.
- R6: The vector word holds the winning source number in bits 31:26 and zero in bits 25:0. It reads 0 when nothing enabled is pending. Writes to it have no effect.
- R7: When several enabled sources are pending, the lowest source number wins the vector.
- R8: Fixed sources (every used source outside 19..25 and 48..63) are active-low level inputs whatever the sense word holds. Clearing such a bit while its line is still low sets it again.
- R9: External source n (19..25) uses sense bit 33-n. With that bit 0 the source is level-sensitive (active low). With it 1, only a high-to-low transition sets the pending bit.
- R10: Port source n (48..63) uses sense bit n-32. With that bit 0, both transitions set the pending bit. With it 1, only falling transitions do.
- R11: Source numbers 0 and 31 never become pending, and the vector never reports 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| src_n | input | 64 | Interrupt lines, active low, bit n is source n |
| irq_out | output | 1 | Request: some enabled source is pending |

## Verification
Two functions can fall in the same cycle: a new event setting a pending bit, and a software write-one clearing that same bit. The first way to provoke this is a level source whose line stays low while the clear is written; the bit must read set again afterwards. The second is a port line driven low with the clear timed onto the exact edge where its synchronized edge reaches the pending flop; the vector must still report that source. Both sweeps over all 64 sources, once with the sense word zero and once with it all ones, then judge every mode's response to a low line, a clear and a release against values the bench computes from the source number.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int SRC_COUNT = 64;
    localparam int REG_W     = 32;
    localparam int CODE_W    = 6;
    localparam int CODE_LSB  = REG_W - CODE_W;
    localparam int ADDR_W    = 3;

    localparam logic [ADDR_W-1:0] A_MASK_H = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK_L = 3'd1;
    localparam logic [ADDR_W-1:0] A_PEND_H = 3'd2;
    localparam logic [ADDR_W-1:0] A_PEND_L = 3'd3;
    localparam logic [ADDR_W-1:0] A_SENSE  = 3'd4;
    localparam logic [ADDR_W-1:0] A_VECTOR = 3'd5;

    // detector mode of one line
    typedef enum logic [1:0] {
        SNS_OFF,
        SNS_LEVEL,
        SNS_FALL,
        SNS_BOTH
    } sense_mode_e;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_FIXED,
        CLS_EXT,
        CLS_PORT
    } src_class_e;

    function automatic src_class_e src_class(input int n);
        if (n <= 0 || n == 31 || n >= SRC_COUNT) return CLS_NONE;
        if (n >= 19 && n <= 25)                  return CLS_EXT;
        if (n >= 48)                             return CLS_PORT;
        return CLS_FIXED;
    endfunction

    function automatic logic src_in_high(input int n);
        return (n < 16) || (n >= 32 && n < 48);
    endfunction

    // bit inside its word; for external and port sources the sense
    // bit happens to sit at this same position
    function automatic logic [4:0] src_bitpos(input int n);
        int p;
        if      (n < 16) p = 16 - n;
        else if (n < 19) p = 18 - n;
        else if (n < 31) p = 33 - n;
        else if (n < 48) p = 63 - n;
        else             p = n - 32;
        return 5'(p);
    endfunction
endpackage

// File: rtl/sic_line.sv
module sic_line
    import sic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_n,
    input  sense_mode_e mode,
    output logic        hit
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] stg;
    logic             cur;
    logic             prv;

    // idle lines are high, so reset to ones to avoid a false edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '1;
        else        stg <= {stg[DEPTH-2:0], line_n};
    end

    assign cur = stg[DEPTH-2];
    assign prv = stg[DEPTH-1];

    always_comb begin
        unique case (mode)
            SNS_OFF:   hit = 1'b0;
            SNS_LEVEL: hit = ~cur;
            SNS_FALL:  hit = prv & ~cur;
            SNS_BOTH:  hit = prv ^ cur;
        endcase
    end
endmodule

// File: rtl/sic_pend_bank.sv
module sic_pend_bank #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    // a set in the same cycle as a clear wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/sic_prio.sv
module sic_prio #(
    parameter int N      = 64,
    parameter int CODE_W = 6
) (
    input  logic [N-1:0]      req,
    output logic [CODE_W-1:0] code,
    output logic              any
);
    always_comb begin
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) code = CODE_W'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/scatter_intc.sv
module scatter_intc
    import sic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [SRC_COUNT-1:0] src_n,
    output logic                 irq_out
);
    logic [REG_W-1:0]     mask_hi_q;
    logic [REG_W-1:0]     mask_lo_q;
    logic [REG_W-1:0]     sense_q;
    logic [REG_W-1:0]     pend_hi_view;
    logic [REG_W-1:0]     pend_lo_view;
    logic [REG_W-1:0]     vec_word;
    logic [SRC_COUNT-1:0] hit;
    logic [SRC_COUNT-1:0] pend;
    logic [SRC_COUNT-1:0] enab;
    logic [SRC_COUNT-1:0] clr;
    logic [CODE_W-1:0]    win_code;
    logic                 win_any;
    sense_mode_e          mode [SRC_COUNT];

    logic wr, wr_pend_h, wr_pend_l;
    assign wr        = bus_en & bus_we;
    assign wr_pend_h = wr && (bus_addr == A_PEND_H);
    assign wr_pend_l = wr && (bus_addr == A_PEND_L);

    // writable words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_hi_q <= '0;
            mask_lo_q <= '0;
            sense_q   <= '0;
        end else if (wr) begin
            if (bus_addr == A_MASK_H) mask_hi_q <= bus_wdata;
            if (bus_addr == A_MASK_L) mask_lo_q <= bus_wdata;
            if (bus_addr == A_SENSE)  sense_q   <= bus_wdata;
        end
    end

    // per-source mode, enable and clear from the scattered map
    always_comb begin
        for (int n = 0; n < SRC_COUNT; n++) begin
            logic [4:0] b;
            logic       hi;
            b       = src_bitpos(n);
            hi      = src_in_high(n);
            enab[n] = 1'b0;
            clr[n]  = 1'b0;
            unique case (src_class(n))
                CLS_NONE:  mode[n] = SNS_OFF;
                CLS_FIXED: mode[n] = SNS_LEVEL;
                CLS_EXT:   mode[n] = sense_q[b] ? SNS_FALL : SNS_LEVEL;
                CLS_PORT:  mode[n] = sense_q[b] ? SNS_FALL : SNS_BOTH;
            endcase
            if (src_class(n) != CLS_NONE) begin
                enab[n] = hi ? mask_hi_q[b] : mask_lo_q[b];
                clr[n]  = bus_wdata[b] & (hi ? wr_pend_h : wr_pend_l);
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < SRC_COUNT; g++) begin : g_line
            sic_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
                .clk    (clk),
                .rst_n  (rst_n),
                .line_n (src_n[g]),
                .mode   (mode[g]),
                .hit    (hit[g])
            );
        end
    endgenerate

    sic_pend_bank #(.N(SRC_COUNT)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hit),
        .clr_i  (clr),
        .pend_o (pend)
    );

    sic_prio #(.N(SRC_COUNT), .CODE_W(CODE_W)) u_prio (
        .req  (pend & enab),
        .code (win_code),
        .any  (win_any)
    );

    assign irq_out  = win_any;
    assign vec_word = {win_code, {CODE_LSB{1'b0}}};

    // pending words as software sees them
    always_comb begin
        pend_hi_view = '0;
        pend_lo_view = '0;
        for (int n = 0; n < SRC_COUNT; n++) begin
            if (src_class(n) != CLS_NONE) begin
                if (src_in_high(n)) pend_hi_view[src_bitpos(n)] = pend[n];
                else                pend_lo_view[src_bitpos(n)] = pend[n];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            case (bus_addr)
                A_MASK_H: bus_rdata = mask_hi_q;
                A_MASK_L: bus_rdata = mask_lo_q;
                A_PEND_H: bus_rdata = pend_hi_view;
                A_PEND_L: bus_rdata = pend_lo_view;
                A_SENSE:  bus_rdata = sense_q;
                A_VECTOR: bus_rdata = vec_word;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sic_checker.sv
module sic_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic [31:0] vec,
    input logic [31:0] mask_hi,
    input logic [31:0] mask_lo
);
    AST_IRQ_MATCHES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (vec[31:26] != 6'd0)); // R5

    AST_VECTOR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        vec[25:0] == 26'd0); // R6

    AST_NO_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        vec[31:26] != 6'd31); // R11

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_hi == 32'd0 && mask_lo == 32'd0) |-> !irq); // R5
endmodule

bind scatter_intc sic_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq_out),
    .vec     (vec_word),
    .mask_hi (mask_hi_q),
    .mask_lo (mask_lo_q)
);

// File: tb/tb_scatter_intc.sv
module tb_scatter_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_n = '1;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scatter_intc dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_n(src_n), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // 0 unused, 1 level, 2 falling, 3 both
    function automatic int mode_of(input int n, input logic [31:0] s);
        if (n == 0 || n == 31) return 0;
        if (n >= 19 && n <= 25) return s[33 - n] ? 2 : 1;
        if (n >= 48) return s[n - 32] ? 2 : 3;
        return 1;
    endfunction

    function automatic logic [63:0] loc_of(input int n);
        logic [63:0] r;
        r = '0;
        if (n >= 1 && n <= 15)       r[32 + 16 - n] = 1'b1;
        else if (n >= 32 && n <= 47) r[32 + 63 - n] = 1'b1;
        else if (n >= 16 && n <= 18) r[18 - n] = 1'b1;
        else if (n >= 19 && n <= 30) r[33 - n] = 1'b1;
        else if (n >= 48)            r[n - 32] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] vec_of(input int n);
        return 32'(n) << 26;
    endfunction

    task automatic clear_all();
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
    endtask

    task automatic sweep(input logic [31:0] s);
        logic [31:0] v, ph, pl;
        wr(3'd4, s);
        for (int n = 0; n < 64; n++) begin
            int m;
            m = mode_of(n, s);
            src_n[n] = 1'b0;
            idle(4);
            rd(3'd5, v);
            check((m == 0) ? "R11 unused low" : "R6 vector on low", v, (m == 0) ? 32'd0 : vec_of(n));
            rd(3'd2, ph);
            rd(3'd3, pl);
            check("R3 map", {ph, pl}, (m == 0) ? 64'd0 : loc_of(n));
            clear_all();
            idle(2);
            rd(3'd5, v);
            check((m == 1) ? "R8 R9 level re-pend" : "R4 clear edge held", v, (m == 1) ? vec_of(n) : 32'd0);
            src_n[n] = 1'b1;
            idle(4);
            rd(3'd5, v);
            check((m == 3) ? "R10 rising both" : "R9 R10 release", v, (m == 3 || m == 1) ? vec_of(n) : 32'd0);
            clear_all();
            idle(2);
            rd(3'd5, v);
            check("R4 cleared", v, 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1 reset word", v, 32'd0);
        end
        check("R1 irq reset", {31'd0, irq_out}, 32'd0);

        // R2 register map readback
        wr(3'd0, 32'hA5A5_0F0F);
        wr(3'd1, 32'h1234_5678);
        wr(3'd4, 32'h8000_4001);
        rd(3'd0, v); check("R2 mask high", v, 32'hA5A5_0F0F);
        rd(3'd1, v); check("R2 mask low", v, 32'h1234_5678);
        rd(3'd4, v); check("R2 sense", v, 32'h8000_4001);
        rd(3'd7, v); check("R2 unmapped", v, 32'd0);

        // R5 masked source still pends, irq waits for mask
        wr(3'd0, 32'd0); wr(3'd1, 32'd0); wr(3'd4, 32'd0);
        src_n[5] = 1'b0;
        idle(4);
        rd(3'd2, v); check("R5 pend while masked", v, 32'h0000_0800);
        check("R5 irq masked", {31'd0, irq_out}, 32'd0);
        rd(3'd5, v); check("R5 vector masked", v, 32'd0);
        wr(3'd0, 32'h0000_0800);
        idle(1);
        check("R5 irq enabled", {31'd0, irq_out}, 32'd1);
        rd(3'd5, v); check("R5 vector enabled", v, vec_of(5));

        // R6 vector write ignored
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, v); check("R6 vector write ignored", v, vec_of(5));

        // R7 priority
        wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
        src_n[40] = 1'b0;
        idle(4);
        rd(3'd5, v); check("R7 5 over 40", v, vec_of(5));
        src_n[5] = 1'b1;
        idle(4);
        clear_all();
        idle(2);
        rd(3'd5, v); check("R7 40 after 5 gone", v, vec_of(40));
        src_n[40] = 1'b1;
        idle(4);
        clear_all();
        wr(3'd4, 32'hFFFF_0000);
        src_n[63] = 1'b0; src_n[48] = 1'b0;
        idle(4);
        rd(3'd5, v); check("R7 48 over 63", v, vec_of(48));

        // R4 zero write keeps pending
        wr(3'd3, 32'h0000_0000);
        rd(3'd3, v); check("R4 zero write", v, 32'h8001_0000);
        src_n[63] = 1'b1; src_n[48] = 1'b1;
        idle(4);
        clear_all();
        idle(2);
        rd(3'd3, v); check("R10 falling mode ignores rise", v, 32'd0);

        // R4 set beats clear on the same edge (port 50, both edges)
        wr(3'd4, 32'd0);
        @(negedge clk); src_n[50] = 1'b0;   // sampled at edge A
        @(negedge clk);                     // after A
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);                     // write lands at A+1... hold one more
        @(negedge clk);                     // covers edge A+2 where hit is live
        bus_en = 1'b0; bus_we = 1'b0;
        rd(3'd5, v); check("R4 set wins over clear", v, vec_of(50));
        src_n[50] = 1'b1;
        idle(4);
        clear_all();
        idle(2);

        // full sweeps: sense all clear, then all set
        sweep(32'h0000_0000);
        sweep(32'hFFFF_FFFF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule